// File: doc/BRIEF.md
# ADC Result Gain and Offset Correction

This block sits between an analog-to-digital converter's raw output and the register that holds the result. It trims each conversion before it is stored. First it removes a programmable signed offset from the raw 12-bit sample. Then it scales the difference by an unsigned fixed-point gain with one integer bit and eleven fraction bits. It rounds the product to the nearest code and clamps it into the 12-bit output range. When correction is turned off, the raw sample is passed through untouched.

Both paths have the same fixed latency of two clock cycles, so a consumer never has to track which mode is active. The enable, gain and offset are sampled on the same clock edge as the raw sample they apply to. Settings can therefore change from one sample to the next. Samples may arrive back to back on every clock.

Top module: `adc_gain_offset_corr`

## Requirements
- R1: When `corr_en` is 0 for a sample, the output value equals the raw sample exactly.
- R2: When `corr_en` is 1, the output is floor(((raw − offset) × gain + 1024) / 2048), which rounds to nearest with exact halves rounded upward, before clamping.
- R3: `offset_word` is a 12-bit two's-complement value: 0x000–0x7FF are 0 to 2047 and 0x800–0xFFF are −2048 to −1, so a negative offset raises the result.
- R4: `gain_word` is unsigned with 1 integer bit and 11 fraction bits: 0x800 is unity gain (the output equals raw − offset), 0x400 is one half and 0xFFF is just under two.
- R5: A corrected value below zero is output as 0, and in particular any sample with raw ≤ offset (signed) gives 0.
- R6: A corrected value above 4095 is output as 4095.
- R7: `res_valid` is asserted exactly two clock edges after the `raw_valid` it belongs to, and samples presented on consecutive cycles come out on consecutive cycles in order.
- R8: While `res_valid` is 0, `res_data` keeps its last value, and input changes without `raw_valid` have no effect on it.
- R9: While `rst` is high and after it is released, `res_valid` is 0 and `res_data` is 0 until the first result.
- R10: The enable, gain and offset are taken from the same cycle as the raw sample, so each sample in a back-to-back stream uses its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | 12 | Raw unsigned conversion result |
| corr_en | input | 1 | 1 applies correction, 0 passes the sample through |
| gain_word | input | 12 | Gain, unsigned 1.11 fixed point |
| offset_word | input | 12 | Offset, two's complement |
| res_valid | output | 1 | Corrected result strobe |
| res_data | output | 12 | Corrected result |

## Verification
Single samples first exercise the pass-through path and the unity-gain case, which separate a wrong mode select from a wrong multiplier. Positive and negative offsets with half-scale and near-double gains then check the sign extension of the offset and the fixed-point alignment of the gain. Odd raw values at half gain land exactly on a rounding boundary, which separates round-half-up from truncation. Out-of-range inputs at both ends show clamping rather than wraparound. A back-to-back stream that switches settings on every sample, followed by idle cycles with moving inputs, separates correct per-sample alignment of the settings from settings that lag or lead by a cycle, and shows that the output holds while idle.

// File: rtl/gocorr_pkg.sv
package gocorr_pkg;
  localparam int DATA_W    = 12;
  localparam int GAIN_W    = 12;
  localparam int GAIN_FRAC = 11;
  localparam int DIFF_W    = DATA_W + 2;

  typedef struct packed {
    logic                     vld;
    logic                     en;
    logic [DATA_W-1:0]        raw;
    logic signed [DIFF_W-1:0] diff;
    logic [GAIN_W-1:0]        gain;
  } s1_t;
endpackage

// File: rtl/gocorr_offset_stage.sv
module gocorr_offset_stage
  import gocorr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int GW = GAIN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [DW-1:0] in_raw,
  input  logic          in_en,
  input  logic [GW-1:0] in_gain,
  input  logic [DW-1:0] in_off,
  output s1_t           s1
);
  localparam int DFW = DW + 2;

  logic signed [DFW-1:0] diff_c;

  // raw is unsigned, offset is two's complement; both widened to DFW
  always_comb begin
    diff_c = $signed({2'b00, in_raw}) - DFW'($signed(in_off));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
    end else begin
      s1.vld <= in_vld;
      if (in_vld) begin
        s1.en   <= in_en;
        s1.raw  <= in_raw;
        s1.diff <= diff_c;
        s1.gain <= in_gain;
      end
    end
  end
endmodule

// File: rtl/gocorr_scale_stage.sv
module gocorr_scale_stage
  import gocorr_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int GW        = GAIN_W,
  parameter int FRAC      = GAIN_FRAC,
  parameter bit ROUND_NEAR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  s1_t           s1,
  output logic          out_vld,
  output logic [DW-1:0] out_data
);
  localparam int DFW    = DW + 2;
  localparam int PROD_W = DFW + GW + 1;
  localparam logic signed [PROD_W-1:0] HALF_LSB =
    {{(PROD_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] MAX_OUT =
    {{(PROD_W-DW){1'b0}}, {DW{1'b1}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] scaled;
  logic [DW-1:0]            clamped;
  logic [DW-1:0]            next_data;

  always_comb begin
    prod = PROD_W'(s1.diff) * PROD_W'($signed({1'b0, s1.gain}));
  end

  generate
    if (ROUND_NEAR) begin : g_round
      always_comb biased = prod + HALF_LSB;
    end else begin : g_trunc
      always_comb biased = prod;
    end
  endgenerate

  always_comb begin
    scaled = biased >>> FRAC;
    if (scaled < 0)
      clamped = '0;
    else if (scaled > MAX_OUT)
      clamped = '1;
    else
      clamped = scaled[DW-1:0];
    next_data = s1.en ? clamped : s1.raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= s1.vld;
      if (s1.vld)
        out_data <= next_data;
    end
  end
endmodule

// File: rtl/adc_gain_offset_corr.sv
module adc_gain_offset_corr
  import gocorr_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int GW   = GAIN_W,
  parameter int FRAC = GAIN_FRAC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw_valid,
  input  logic [DW-1:0] raw_data,
  input  logic          corr_en,
  input  logic [GW-1:0] gain_word,
  input  logic [DW-1:0] offset_word,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  s1_t s1;

  gocorr_offset_stage #(.DW(DW), .GW(GW)) u_off (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (raw_valid),
    .in_raw  (raw_data),
    .in_en   (corr_en),
    .in_gain (gain_word),
    .in_off  (offset_word),
    .s1      (s1)
  );

  gocorr_scale_stage #(.DW(DW), .GW(GW), .FRAC(FRAC), .ROUND_NEAR(1'b1)) u_scl (
    .clk      (clk),
    .rst      (rst),
    .s1       (s1),
    .out_vld  (res_valid),
    .out_data (res_data)
  );
endmodule

// File: rtl/gocorr_checker.sv
module gocorr_checker #(
  parameter int DW = 12,
  parameter int GW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          raw_valid,
  input logic [DW-1:0] raw_data,
  input logic          corr_en,
  input logic [GW-1:0] gain_word,
  input logic [DW-1:0] offset_word,
  input logic          res_valid,
  input logic [DW-1:0] res_data
);
  logic [1:0] since_rst;
  logic       primed;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign primed = (since_rst >= 2'd2);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    primed |-> (res_valid == $past(raw_valid, 2))); // R7

  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(raw_valid && !corr_en, 2)) |-> (res_data == $past(raw_data, 2))); // R1

  AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(raw_valid && corr_en && gain_word == {1'b1, {(GW-1){1'b0}}}
                     && offset_word == '0, 2)) |-> (res_data == $past(raw_data, 2))); // R4

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(raw_valid && corr_en &&
       ($signed({1'b0, raw_data}) <= $signed({offset_word[DW-1], offset_word})), 2))
    |-> (res_data == '0)); // R5

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(raw_valid && corr_en && raw_data == '1 && gain_word[GW-1] &&
       (offset_word[DW-1] || offset_word == '0), 2)) |-> (res_data == '1)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (primed && !res_valid) |-> $stable(res_data)); // R8
endmodule

bind adc_gain_offset_corr gocorr_checker #(.DW(DW), .GW(GW)) u_chk (.*);

// File: tb/adc_gain_offset_corr_bench.sv
module adc_gain_offset_corr_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        raw_valid;
  logic [11:0] raw_data;
  logic        corr_en;
  logic [11:0] gain_word;
  logic [11:0] offset_word;
  logic        res_valid;
  logic [11:0] res_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  adc_gain_offset_corr u_adc_gain_offset_corr (
    .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_data(raw_data),
    .corr_en(corr_en), .gain_word(gain_word), .offset_word(offset_word),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [11:0] model(input logic [11:0] raw, input logic en,
                                        input logic [11:0] g, input logic [11:0] o);
    int d, p, r;
    if (!en) return raw;
    d = int'(raw) - int'($signed(o));
    p = d * int'(g);
    r = (p + 1024) >>> 11;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return 12'(r);
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp_v);
    end
  endtask

  // drive one sample at a negedge, check two edges later
  task automatic one(input string req, input logic [11:0] r, input logic e,
                     input logic [11:0] g, input logic [11:0] o);
    raw_valid = 1'b1; raw_data = r; corr_en = e; gain_word = g; offset_word = o;
    @(negedge clk);
    raw_valid = 1'b0;
    chk_bit({req, " not early"}, res_valid, 1'b0);
    @(negedge clk);
    chk_bit({req, " valid"}, res_valid, 1'b1);
    chk(req, res_data, model(r, e, g, o));
  endtask

  task automatic t_reset;
    rst = 1'b1; raw_valid = 1'b1; raw_data = 12'hABC; corr_en = 1'b0;
    gain_word = 12'h800; offset_word = 12'h000;
    repeat (3) @(negedge clk);
    chk_bit("R9 valid in reset", res_valid, 1'b0);
    chk("R9 data in reset", res_data, 12'd0);
    raw_valid = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_bit("R9 valid after reset", res_valid, 1'b0);
    chk("R9 data after reset", res_data, 12'd0);
  endtask

  task automatic t_bypass;
    one("R1 bypass", 12'd3001, 1'b0, 12'h400, 12'h123);
    one("R1 bypass max", 12'hFFF, 1'b0, 12'hFFF, 12'h7FF);
  endtask

  task automatic t_gain;
    one("R4 unity", 12'd1234, 1'b1, 12'h800, 12'h000);
    chk("R4 unity literal", res_data, 12'd1234);
    one("R4 half", 12'd100, 1'b1, 12'h400, 12'h000);
    chk("R4 half literal", res_data, 12'd50);
    one("R4 near double", 12'd1000, 1'b1, 12'hFFF, 12'h000);
    chk("R4 near double literal", res_data, 12'd2000);
  endtask

  task automatic t_offset;
    one("R3 positive offset", 12'd1000, 1'b1, 12'h800, 12'd24);
    chk("R3 positive literal", res_data, 12'd976);
    one("R3 negative offset", 12'd1000, 1'b1, 12'h800, 12'hFE8);
    chk("R3 negative literal", res_data, 12'd1024);
    one("R2 mixed", 12'd2500, 1'b1, 12'h9A3, 12'hF80);
  endtask

  task automatic t_round;
    one("R2 half rounds up", 12'd1, 1'b1, 12'h400, 12'h000);
    chk("R2 1 x 0.5 literal", res_data, 12'd1);
    one("R2 1.5 rounds up", 12'd3, 1'b1, 12'h400, 12'h000);
    chk("R2 3 x 0.5 literal", res_data, 12'd2);
    one("R2 below half", 12'd1, 1'b1, 12'h3FF, 12'h000);
  endtask

  task automatic t_sat;
    one("R5 low clamp", 12'd5, 1'b1, 12'h800, 12'd10);
    chk("R5 low literal", res_data, 12'd0);
    one("R5 equal gives zero", 12'd300, 1'b1, 12'hFFF, 12'd300);
    chk("R5 equal literal", res_data, 12'd0);
    one("R6 high clamp", 12'd4000, 1'b1, 12'hFFF, 12'h000);
    chk("R6 high literal", res_data, 12'd4095);
    one("R6 neg offset overflow", 12'hFFF, 1'b1, 12'h800, 12'h800);
    chk("R6 overflow literal", res_data, 12'd4095);
  endtask

  // back-to-back samples, settings change every sample
  task automatic t_stream;
    logic [11:0] r[8], g[8], o[8];
    logic        e[8];
    for (int i = 0; i < 8; i++) begin
      r[i] = 12'(200 + 437 * i);
      e[i] = (i % 3) != 1;
      g[i] = 12'(12'h400 + 12'(i * 300));
      o[i] = (i % 2) ? 12'(4096 - 17 * i) : 12'(9 * i);
    end
    for (int k = 0; k < 10; k++) begin
      if (k >= 2) begin
        chk_bit("R7 stream valid", res_valid, 1'b1);
        chk("R10 stream data", res_data, model(r[k-2], e[k-2], g[k-2], o[k-2]));
      end
      if (k < 8) begin
        raw_valid = 1'b1; raw_data = r[k]; corr_en = e[k];
        gain_word = g[k]; offset_word = o[k];
      end else begin
        raw_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk_bit("R7 stream ends", res_valid, 1'b0);
  endtask

  task automatic t_hold;
    logic [11:0] keep;
    one("R8 seed", 12'd777, 1'b1, 12'h800, 12'd7);
    keep = res_data;
    for (int i = 0; i < 4; i++) begin
      raw_data = 12'(i * 999); corr_en = i[0]; gain_word = 12'hFFF; offset_word = 12'h800;
      @(negedge clk);
      chk_bit("R8 idle no valid", res_valid, 1'b0);
      chk("R8 idle holds", res_data, keep);
    end
  endtask

  initial begin
    raw_valid = 1'b0; raw_data = '0; corr_en = 1'b0; gain_word = '0; offset_word = '0;
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_gain();
    t_offset();
    t_round();
    t_sat();
    t_stream();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule